// File: doc/BRIEF.md
# System Clock Ratio Detector

This block watches the frame-rate (word select) line of a serial audio link that runs as a slave. It counts how many system-clock cycles fit between two rising edges of that line, and it matches the count against the fixed set of clock-to-sample-rate ratios the converter path can use: 128, 192, 256, 384, 512 and 768. Once the same ratio has been seen in three periods in a row, the block reports it as locked. It then drives a single-cycle strobe at the noise-shaper rate. No configuration is needed, because the system clock is assumed to be frequency-locked to the frame line.

A two-bit mode input carries a three-level setting. In normal operation the strobe runs at 64 pulses per frame. In low-sample-rate operation it runs at 128 pulses per frame, and the two smallest ratios become illegal. In sleep, lock, error and strobe are all held off. If a frame length does not fit any allowed ratio, or disagrees with the locked ratio, or the frame line stops, the lock drops and an error flag stays raised until the block acquires lock again.

Top module: `ratio_detector`

## Requirements
- R1: After reset, ratioValid=0, ratioErr=0, ratioCode=7 and osStrobe=0.
- R2: A frame of N cycles (rising edge to rising edge) matches a ratio when N lies within ±2 cycles of its nominal value. The codes are 128→0, 192→1, 256→2, 384→3, 512→4 and 768→5. While ratioValid=0, ratioCode reads 7.
- R3: The first rising edge after reset yields no measurement. ratioValid rises only after three consecutive measurements match the same ratio, so two matching measurements leave ratioValid=0 and ratioErr=0.
- R4: In normal mode (modeSel=00), while ratioValid=1, osStrobe pulses once every nominal/64 cycles, which gives 64 pulses per frame. It never pulses on two consecutive cycles and never pulses while ratioValid=0.
- R5: In low-sample-rate mode (modeSel=01), while ratioValid=1, osStrobe pulses once every nominal/128 cycles, which gives 128 pulses per frame.
- R6: In low-sample-rate mode, frames of 128 or 192 cycles count as errors. When that mode is entered while the locked code is 0 or 1, ratioValid falls at once.
- R7: With modeSel[1]=1 (sleep), ratioValid=0 and osStrobe=0, ratioErr is cleared and the match history is discarded. After wake-up, three new matching measurements are needed to lock.
- R8: A measurement that matches no allowed ratio, or matches a ratio other than the locked one, clears ratioValid and sets ratioErr. ratioErr stays set until lock is regained.
- R9: If no rising edge arrives for 2^CNT_W−1 cycles (2047 by default), ratioValid is cleared and ratioErr is set.
- R10: ratioValid and ratioErr are never high together, and ratioCode does not change while ratioValid stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ws | input | 1 | Frame-rate line, asynchronous to clk |
| modeSel | input | 2 | 00 normal, 01 low sample rate, 1x sleep |
| ratioCode | output | 3 | Locked ratio code, 7 when not locked |
| ratioValid | output | 1 | Ratio locked and usable |
| ratioErr | output | 1 | Unsupported, unstable or missing frame |
| osStrobe | output | 1 | Single-cycle oversampling strobe |

## Verification
The assertions check, on every cycle, that the strobe only appears while the lock is valid and never on two cycles in a row, that lock and error are mutually exclusive, that the reported code is legal and holds steady during lock, and that the error flag is cleared once sleep has lasted one cycle. The bench scenarios are the only place where the following are shown: the actual ratio classification and its tolerance edges, the three-period acquisition, the strobe counts per frame in each mode, the low-rate exclusions, relock after sleep, and the inactivity timeout.

// File: rtl/ratio_det_pkg.sv
package ratio_det_pkg;

  localparam int NUM_RATIOS = 6;
  localparam int DIV_W = 4;
  localparam logic [2:0] CODE_NONE = 3'd7;

  // control -> datapath
  typedef struct packed {
    logic             run;
    logic             lowRate;
    logic [DIV_W-1:0] divisor;
  } ctlT;

  // datapath -> control: one frame measurement
  typedef struct packed {
    logic       valid;
    logic       ok;
    logic [2:0] code;
  } measT;

  function automatic int unsigned nominalOf(input int idx);
    case (idx)
      0: return 128;
      1: return 192;
      2: return 256;
      3: return 384;
      4: return 512;
      5: return 768;
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/ratio_det_datapath.sv
module ratio_det_datapath
  import ratio_det_pkg::*;
#(
  parameter int CNT_W = 11,
  parameter int TOL   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic ws,
  input  ctlT  ctl,
  output measT meas,
  output logic osStrobe
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [2:0] wsSync;
  logic       wsRise;
  logic [CNT_W-1:0] cnt;
  logic       haveEdge;
  logic       atLimit;
  logic [31:0] cntWide;
  logic [NUM_RATIOS-1:0] hit;
  logic [2:0] hitCode;
  logic [DIV_W-1:0] divCnt;

  // two synchroniser flops plus one history flop for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wsSync <= '0;
    else       wsSync <= {wsSync[1:0], ws};
  end
  assign wsRise = wsSync[1] & ~wsSync[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt      <= '0;
      haveEdge <= 1'b0;
    end else if (wsRise) begin
      cnt      <= CNT_W'(1);
      haveEdge <= 1'b1;
    end else if (cnt != CNT_MAX) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign atLimit = haveEdge && !wsRise && (cnt == CNT_MAX - CNT_W'(1));
  assign cntWide = 32'(cnt);

  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_cls
    localparam int NOM = int'(nominalOf(i));
    localparam logic [31:0] LO = 32'(NOM - TOL);
    localparam logic [31:0] HI = 32'(NOM + TOL);
    localparam bit LOW_OK = (NOM >= 256);
    assign hit[i] = (cntWide >= LO) && (cntWide <= HI) && (LOW_OK || !ctl.lowRate);
  end

  always_comb begin
    hitCode = '0;
    for (int i = 0; i < NUM_RATIOS; i++) begin
      if (hit[i]) hitCode = 3'(i);
    end
  end

  assign meas.valid = (wsRise && haveEdge) || atLimit;
  assign meas.ok    = wsRise && (|hit);
  assign meas.code  = hitCode;

  // strobe divider, realigned on every frame edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               divCnt <= '0;
    else if (!ctl.run || wsRise)             divCnt <= '0;
    else if (divCnt >= ctl.divisor - DIV_W'(1)) divCnt <= '0;
    else                                     divCnt <= divCnt + DIV_W'(1);
  end

  assign osStrobe = ctl.run && (divCnt == ctl.divisor - DIV_W'(1));

endmodule

// File: rtl/ratio_det_control.sv
module ratio_det_control
  import ratio_det_pkg::*;
#(
  parameter int LOCK_PERIODS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  measT       meas,
  output ctlT        ctl,
  output logic       ratioValid,
  output logic       ratioErr,
  output logic [2:0] ratioCode
);

  localparam int AGR_W = $clog2(LOCK_PERIODS + 1);
  localparam logic [AGR_W-1:0] AGR_LOCK = AGR_W'(LOCK_PERIODS - 1);

  logic sleep, lowRate, masked;
  logic locked, errFlag;
  logic [2:0] cand;
  logic [AGR_W-1:0] agree;
  logic [9:0] nom;

  assign sleep   = modeSel[1];
  assign lowRate = (modeSel == 2'b01);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked  <= 1'b0;
      errFlag <= 1'b0;
      cand    <= CODE_NONE;
      agree   <= '0;
    end else if (sleep) begin
      locked  <= 1'b0;
      errFlag <= 1'b0;
      agree   <= '0;
    end else if (meas.valid) begin
      if (!meas.ok) begin
        locked  <= 1'b0;
        errFlag <= 1'b1;
        agree   <= '0;
      end else if (agree != '0 && meas.code == cand) begin
        if (agree == AGR_LOCK) begin
          locked  <= 1'b1;
          errFlag <= 1'b0;
        end else begin
          agree <= agree + AGR_W'(1);
        end
      end else begin
        cand  <= meas.code;
        agree <= AGR_W'(1);
        if (locked) begin
          locked  <= 1'b0;
          errFlag <= 1'b1;
        end
      end
    end
  end

  assign masked     = lowRate && (cand < 3'd2);
  assign ratioValid = locked && !sleep && !masked;
  assign ratioErr   = errFlag;
  assign ratioCode  = ratioValid ? cand : CODE_NONE;

  assign nom         = 10'(nominalOf(int'(cand)));
  assign ctl.run     = ratioValid;
  assign ctl.lowRate = lowRate;
  assign ctl.divisor = lowRate ? DIV_W'(nom >> 7) : DIV_W'(nom >> 6);

endmodule

// File: rtl/ratio_detector.sv
module ratio_detector
  import ratio_det_pkg::*;
#(
  parameter int CNT_W        = 11,
  parameter int TOL          = 2,
  parameter int LOCK_PERIODS = 3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ws,
  input  logic [1:0] modeSel,
  output logic [2:0] ratioCode,
  output logic       ratioValid,
  output logic       ratioErr,
  output logic       osStrobe
);

  ctlT  ctl;
  measT meas;

  ratio_det_datapath #(.CNT_W(CNT_W), .TOL(TOL)) i_datapath (
    .clk(clk), .rstN(rstN), .ws(ws), .ctl(ctl), .meas(meas), .osStrobe(osStrobe)
  );

  ratio_det_control #(.LOCK_PERIODS(LOCK_PERIODS)) i_control (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .meas(meas), .ctl(ctl),
    .ratioValid(ratioValid), .ratioErr(ratioErr), .ratioCode(ratioCode)
  );

endmodule

// File: rtl/ratio_detector_checker.sv
module ratio_detector_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic [2:0] ratioCode,
  input logic       ratioValid,
  input logic       ratioErr,
  input logic       osStrobe
);

  assert_strobe_needs_lock_R4: assert property (@(posedge clk) disable iff (!rstN)
    osStrobe |-> ratioValid);

  assert_strobe_spacing_R4: assert property (@(posedge clk) disable iff (!rstN)
    osStrobe |=> !osStrobe);

  assert_code_legal_R2: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |-> (ratioCode <= 3'd5));

  assert_valid_err_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(ratioValid && ratioErr));

  assert_code_stable_R10: assert property (@(posedge clk) disable iff (!rstN)
    ratioValid |=> (!ratioValid || $stable(ratioCode)));

  assert_sleep_clears_err_R7: assert property (@(posedge clk) disable iff (!rstN)
    modeSel[1] |=> (!modeSel[1] || !ratioErr));

endmodule

bind ratio_detector ratio_detector_checker i_checker (.*);

// File: tb/test_ratio_detector.sv
module test_ratio_detector;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ws = 1'b0;
  logic [1:0] modeSel = 2'b00;
  logic [2:0] ratioCode;
  logic ratioValid, ratioErr, osStrobe;

  int checkCnt = 0;
  int passCnt = 0;
  int failCnt = 0;
  int stbTotal = 0;
  bit finished = 1'b0;

  typedef struct {
    string req;
    int    kind;   // 0: status word {valid,err,code}, 1: strobe count
    int    expV;
    int    gotV;
  } itemT;

  itemT q[$];
  event chkEv;

  ratio_detector i_ratio_detector (
    .clk(clk), .rstN(rstN), .ws(ws), .modeSel(modeSel),
    .ratioCode(ratioCode), .ratioValid(ratioValid),
    .ratioErr(ratioErr), .osStrobe(osStrobe)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (osStrobe) stbTotal <= stbTotal + 1;

  // monitor / scoreboard
  initial begin
    forever begin
      @(chkEv);
      while (q.size() > 0) begin
        itemT it;
        int got;
        it = q.pop_front();
        got = (it.kind == 0) ? int'({ratioValid, ratioErr, ratioCode}) : it.gotV;
        checkCnt++;
        if (got == it.expV) passCnt++;
        else begin
          failCnt++;
          if (it.kind == 0)
            $display("FAIL %s: got {valid,err,code}=%b expected %b",
                     it.req, 5'(got), 5'(it.expV));
          else
            $display("FAIL %s: got %0d strobes expected %0d", it.req, got, it.expV);
        end
      end
    end
  end

  task automatic expectStatus(input string req, input bit v, input bit e, input logic [2:0] c);
    itemT it;
    it.req = req; it.kind = 0; it.expV = int'({v, e, c}); it.gotV = 0;
    q.push_back(it);
    -> chkEv;
    #1;
  endtask

  task automatic expectCount(input string req, input int got, input int exp);
    itemT it;
    it.req = req; it.kind = 1; it.expV = exp; it.gotV = got;
    q.push_back(it);
    -> chkEv;
    #1;
  endtask

  task automatic drivePeriods(input int n, input int len);
    for (int k = 0; k < n; k++) begin
      ws = 1'b1;
      repeat (len / 2) @(negedge clk);
      ws = 1'b0;
      repeat (len - len / 2) @(negedge clk);
    end
  endtask

  task automatic countStrobes(input string req, input int len, input int exp);
    int start;
    start = stbTotal;
    drivePeriods(1, len);
    expectCount(req, stbTotal - start, exp);
  endtask

  initial begin
    int noms[6] = '{128, 192, 256, 384, 512, 768};
    int start;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    expectStatus("R1 reset state", 1'b0, 1'b0, 3'd7);
    start = stbTotal;
    repeat (64) @(negedge clk);
    expectCount("R1 no strobe after reset", stbTotal - start, 0);

    // R3: three matching measurements needed
    drivePeriods(3, 256);
    expectStatus("R3 two measurements not locked", 1'b0, 1'b0, 3'd7);
    drivePeriods(1, 256);
    expectStatus("R3 locked after three", 1'b1, 1'b0, 3'd2);

    // R2 / R4: every ratio in normal mode
    for (int i = 0; i < 6; i++) begin
      drivePeriods(5, noms[i]);
      expectStatus("R2 ratio code", 1'b1, 1'b0, 3'(i));
      countStrobes("R4 64 strobes per frame", noms[i], 64);
    end

    // R2 tolerance edges
    drivePeriods(5, 256);
    drivePeriods(5, 258);
    expectStatus("R2 +2 tolerance", 1'b1, 1'b0, 3'd2);
    drivePeriods(5, 254);
    expectStatus("R2 -2 tolerance", 1'b1, 1'b0, 3'd2);

    // R8: out-of-tolerance frame, then relock
    drivePeriods(1, 259);
    drivePeriods(1, 256);
    expectStatus("R8 unsupported frame flags error", 1'b0, 1'b1, 3'd7);
    drivePeriods(2, 256);
    expectStatus("R8 error held until relock", 1'b0, 1'b1, 3'd7);
    drivePeriods(1, 256);
    expectStatus("R8 relocked", 1'b1, 1'b0, 3'd2);

    // R8: different ratio while locked
    drivePeriods(2, 384);
    expectStatus("R8 ratio change flags error", 1'b0, 1'b1, 3'd7);
    drivePeriods(3, 384);
    expectStatus("R8 locked on new ratio", 1'b1, 1'b0, 3'd3);

    // R5: low-sample-rate strobe
    modeSel = 2'b01;
    drivePeriods(1, 384);
    expectStatus("R5 lock kept at 384 in low mode", 1'b1, 1'b0, 3'd3);
    countStrobes("R5 128 strobes per frame at 384", 384, 128);
    drivePeriods(5, 768);
    expectStatus("R5 low mode 768", 1'b1, 1'b0, 3'd5);
    countStrobes("R5 128 strobes per frame at 768", 768, 128);

    // R6: low ratios rejected in low mode
    drivePeriods(5, 192);
    expectStatus("R6 192 rejected in low mode", 1'b0, 1'b1, 3'd7);
    drivePeriods(5, 128);
    expectStatus("R6 128 rejected in low mode", 1'b0, 1'b1, 3'd7);
    modeSel = 2'b00;
    drivePeriods(5, 128);
    expectStatus("R6 128 accepted in normal mode", 1'b1, 1'b0, 3'd0);
    modeSel = 2'b01;
    repeat (2) @(negedge clk);
    expectStatus("R6 lock masked on low-mode entry", 1'b0, 1'b0, 3'd7);

    // R7: sleep
    modeSel = 2'b00;
    drivePeriods(5, 256);
    expectStatus("R7 locked before sleep", 1'b1, 1'b0, 3'd2);
    modeSel = 2'b10;
    @(negedge clk);
    expectStatus("R7 sleep drops valid", 1'b0, 1'b0, 3'd7);
    countStrobes("R7 no strobes in sleep", 256, 0);
    drivePeriods(2, 300);
    modeSel = 2'b11;
    drivePeriods(2, 256);
    expectStatus("R7 sleep ignores frames and clears error", 1'b0, 1'b0, 3'd7);
    modeSel = 2'b00;
    drivePeriods(2, 256);
    expectStatus("R7 history cleared after wake", 1'b0, 1'b0, 3'd7);
    drivePeriods(1, 256);
    expectStatus("R7 relocked after wake", 1'b1, 1'b0, 3'd2);

    // R9: frame line stops
    repeat (2100) @(negedge clk);
    expectStatus("R9 inactivity error", 1'b0, 1'b1, 3'd7);
    drivePeriods(5, 512);
    expectStatus("R9 recovery after inactivity", 1'b1, 1'b0, 3'd4);

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", passCnt, checkCnt);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checkCnt++;
      failCnt++;
      $display("FAIL R1-watchdog: got running expected finished");
      $display("%0d/%0d checks passed", passCnt, checkCnt);
      $finish;
    end
  end

endmodule